// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block turns a digital "supply above threshold" flag from an external comparator into a clean, active-low system reset. The flag first passes through a two-stage synchroniser. A dropout filter then ignores brief dips, so only a low level that lasts long enough counts as an undervoltage. After the supply comes up, the reset is held for a programmable power-on delay. That delay is the same length as the base period of the downstream watchdog, so the watchdog stays idle and ignores clear pulses until the sequence is complete.

A qualified undervoltage overrides everything else. It drops the reset at once and pulses a force-disable strobe, which turns off critical outputs downstream. Once the flag recovers, the whole power-up sequence runs again from the start. Each time the reset is released at the end of a power-on delay, a one-cycle "sequence done" pulse tells the watchdog that it may begin timing. All times are counted in clock ticks.

Top module: `supply_rst_seq`

## Requirements
- R1: While `rst_ni` is low, and afterwards for as long as the flag stays low, `rst_no` is 0. A low flag that is present from reset counts as an undervoltage already recognised, so it produces no `force_dis_o` pulse.
- R2: `vok_i` is sampled through `SYNC_STAGES` (2) flip-flops before any other logic sees it. A change on the flag therefore takes effect no earlier than the second clock edge after it.
- R3: Suppose `vok_i` is high at rising edge k and stays high. Then `rst_no` goes from 0 to 1 right after edge k+`POR_TICKS`+2.
- R4: A dip in which `vok_i` is sampled low on fewer than `SENS_TICKS` consecutive edges has no visible effect. This holds while the reset is released and also during the power-on delay, where the delay count carries on without restarting.
- R5: Suppose `vok_i` is sampled low on `SENS_TICKS` consecutive edges starting at edge k. Then, right after edge k+`SENS_TICKS`+1, `force_dis_o` is 1 for exactly one cycle and `rst_no` is 0 in that same cycle.
- R6: After a qualified dropout of N ≥ `SENS_TICKS` sampled-low edges starting at edge k, the full power-on delay runs again. `rst_no` rises right after edge k+N+`POR_TICKS`+2.
- R7: `seq_done_o` is 1 for exactly the one cycle in which `rst_no` first reads 1 after being 0, and at no other time.
- R8: A dropout that qualifies on the same edge at which the power-on delay would end takes priority. `rst_no` stays 0, `seq_done_o` does not pulse, and `force_dis_o` pulses.
- R9: One continuous dropout produces only one `force_dis_o` pulse, however long the flag stays low.
- R10: Driving `rst_ni` low forces `rst_no` to 0 at once, without waiting for a clock edge. After `rst_ni` is released, the sequence starts again as at power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous raw reset, active low |
| vok_i | input | 1 | Comparator flag, 1 = supply above threshold (asynchronous) |
| rst_no | output | 1 | System reset, active low |
| seq_done_o | output | 1 | One-cycle pulse when the power-on delay completes and reset releases |
| force_dis_o | output | 1 | One-cycle strobe when an undervoltage is recognised |

## Verification
The risky overlap is a dropout that qualifies in the same cycle as the power-on delay ends. Release and forced reset then compete for that one edge. The bench provokes this by raising the flag and starting a dip exactly `POR_TICKS`-`SENS_TICKS`+1 cycles later. It expects a `force_dis_o` pulse in the cycle the release would have come, with no `seq_done_o` and no `rst_no` rise. It then shifts the same dip one cycle later and expects a one-cycle release with `seq_done_o`, followed at once by the strobe and the reset dropping again.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,  // supply down, reset held
    ST_HOLD = 2'd1,  // supply up, counting power-on delay
    ST_RUN  = 2'd2   // reset released
  } seq_state_e;

endpackage

// File: rtl/supply_rst_sync.sv
module supply_rst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[0] <= RST_VAL;
        else         ff_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= RST_VAL;
        else         ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/supply_rst_filter.sv
module supply_rst_filter #(
  parameter int unsigned SENS_TICKS = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,      // synchronised flag
  output logic qual_o,    // undervoltage holds at this edge
  output logic strobe_o   // registered one-shot on new undervoltage
);

  localparam int unsigned CW = (SENS_TICKS < 2) ? 1 : $clog2(SENS_TICKS);
  localparam logic [CW-1:0] LAST = CW'(SENS_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          uv_q;
  logic          strobe_q;

  // Qualifies on the edge that sees the SENS_TICKS-th consecutive low sample.
  assign qual_o = !ok_i && (uv_q || (cnt_q == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      uv_q     <= 1'b1;  // start as already recognised: no strobe at power-up
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= qual_o && !uv_q;
      if (ok_i) begin
        cnt_q <= '0;
        uv_q  <= 1'b0;
      end else if (qual_o) begin
        uv_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign strobe_o = strobe_q;

endmodule

// File: rtl/supply_rst_fsm.sv
module supply_rst_fsm
  import supply_rst_pkg::*;
#(
  parameter int unsigned POR_TICKS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  input  logic qual_i,
  output logic rst_no,
  output logic done_o
);

  localparam int unsigned PW = (POR_TICKS < 2) ? 1 : $clog2(POR_TICKS);
  localparam logic [PW-1:0] LAST = PW'(POR_TICKS - 1);

  seq_state_e    state_q, state_d;
  logic [PW-1:0] cnt_q;
  logic          rst_q, done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: if (ok_i && !qual_i)     state_d = ST_HOLD;
      ST_HOLD: if (qual_i)              state_d = ST_WAIT;
               else if (cnt_q == LAST)  state_d = ST_RUN;
      ST_RUN:  if (qual_i)              state_d = ST_WAIT;
      default:                          state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      rst_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == ST_HOLD && state_d == ST_HOLD) ? cnt_q + 1'b1 : '0;
      rst_q   <= (state_d == ST_RUN);
      done_q  <= (state_q == ST_HOLD) && (state_d == ST_RUN);
    end
  end

  assign rst_no = rst_q;
  assign done_o = done_q;

endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SENS_TICKS  = 5000,
  parameter int unsigned POR_TICKS   = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vok_i,
  output logic rst_no,
  output logic seq_done_o,
  output logic force_dis_o
);

  logic ok_sync;
  logic qual;

  supply_rst_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (vok_i),
    .q_o   (ok_sync)
  );

  supply_rst_filter #(
    .SENS_TICKS(SENS_TICKS)
  ) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ok_i    (ok_sync),
    .qual_o  (qual),
    .strobe_o(force_dis_o)
  );

  supply_rst_fsm #(
    .POR_TICKS(POR_TICKS)
  ) u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ok_i  (ok_sync),
    .qual_i(qual),
    .rst_no(rst_no),
    .done_o(seq_done_o)
  );

endmodule

// File: rtl/supply_rst_seq_chk.sv
module supply_rst_seq_chk #(
  parameter int unsigned POR_TICKS = 100000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_no,
  input logic seq_done_o,
  input logic force_dis_o
);

  localparam int unsigned LW = $clog2(POR_TICKS + 1) + 1;
  localparam logic [LW-1:0] LIM = LW'(POR_TICKS);

  // consecutive cycles with reset asserted, saturating
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt <= '0;
    else if (rst_no)      low_cnt <= '0;
    else if (low_cnt < LIM) low_cnt <= low_cnt + 1'b1;
  end

  p_release_after_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (low_cnt >= LIM));

  p_strobe_holds_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_dis_o |-> !rst_no);

  p_done_marks_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> (rst_no && !$past(rst_no)));

  p_release_marks_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> seq_done_o);

  p_no_done_with_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seq_done_o && force_dis_o));

  p_strobe_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_dis_o |=> !force_dis_o);

endmodule

bind supply_rst_seq supply_rst_seq_chk #(
  .POR_TICKS(POR_TICKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_no     (rst_no),
  .seq_done_o (seq_done_o),
  .force_dis_o(force_dis_o)
);

// File: tb/supply_rst_seq_tb_top.sv
module supply_rst_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int POR  = 20;
  localparam int SENS = 5;
  localparam int NV   = 6;
  localparam int NONE = -1;

  // dip length vs expected qualification (R4/R5/R6/R9)
  localparam int DIP_LEN  [NV] = '{1, 3, SENS-1, SENS, SENS+1, 3*SENS};
  localparam bit DIP_QUAL [NV] = '{0, 0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vok = 1'b0;
  logic rst_o, done_o, fdis_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_rst_seq #(
    .SYNC_STAGES(2),
    .SENS_TICKS (SENS),
    .POR_TICKS  (POR)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .vok_i      (vok),
    .rst_no     (rst_o),
    .seq_done_o (done_o),
    .force_dis_o(fdis_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Walk span negedges from the current negedge. Stimulus at hi/lo/hi2,
  // expected reset level s0 toggled at fall_at/rise_at, pulses at rise_at/fd_at.
  task automatic trace(input string tag, input int span, input bit s0,
                       input int hi_at, input int lo_at, input int hi2_at,
                       input int fall_at, input int rise_at, input int fd_at);
    int lvl = s0;
    int bad_r = 0, bad_d = 0, bad_f = 0;
    int ar = 0, er = 0, ad = 0, ed = 0, af = 0, ef = 0;
    for (int j = 0; j <= span; j++) begin
      if (j > 0) begin
        @(negedge clk);
        if (j == fall_at) lvl = 0;
        if (j == rise_at) lvl = 1;
        if (int'(rst_o) != lvl && bad_r == 0) begin bad_r = j; ar = rst_o; er = lvl; end
        if (int'(done_o) != int'(j == rise_at) && bad_d == 0) begin
          bad_d = j; ad = done_o; ed = int'(j == rise_at);
        end
        if (int'(fdis_o) != int'(j == fd_at) && bad_f == 0) begin
          bad_f = j; af = fdis_o; ef = int'(j == fd_at);
        end
      end
      if (j == hi_at)  vok = 1'b1;
      if (j == lo_at)  vok = 1'b0;
      if (j == hi2_at) vok = 1'b1;
    end
    if (bad_r != 0) $display("  %s rst_no first mismatch at cycle %0d", tag, bad_r);
    if (bad_d != 0) $display("  %s seq_done first mismatch at cycle %0d", tag, bad_d);
    if (bad_f != 0) $display("  %s force_dis first mismatch at cycle %0d", tag, bad_f);
    chk({tag, " rst_no"}, ar, er);
    chk({tag, " seq_done_o"}, ad, ed);
    chk({tag, " force_dis_o"}, af, ef);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1/R10: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset rst_no", rst_o, 0);
    chk("R1 reset seq_done_o", done_o, 0);
    chk("R1 reset force_dis_o", fdis_o, 0);
    rst_n = 1'b1;

    // R1: flag low after reset, reset held, no strobe
    trace("R1 low flag", 30, 0, NONE, NONE, NONE, NONE, NONE, NONE);

    // R2/R3/R7: power-up delay
    trace("R3 bring-up", POR+6, 0, 0, NONE, NONE, NONE, POR+3, NONE);

    // R4/R5/R6/R9: dip table from released state
    for (int v = 0; v < NV; v++) begin
      if (DIP_QUAL[v])
        trace($sformatf("R5 R6 R9 dip len %0d", DIP_LEN[v]), DIP_LEN[v]+POR+6, 1,
              NONE, 0, DIP_LEN[v], SENS+2, DIP_LEN[v]+POR+3, SENS+2);
      else
        trace($sformatf("R4 dip len %0d", DIP_LEN[v]), SENS+8, 1,
              NONE, 0, DIP_LEN[v], NONE, NONE, NONE);
    end

    // R4: short dip during power-on delay does not restart it
    trace("R5 drop to wait", SENS+6, 1, NONE, 0, NONE, SENS+2, NONE, SENS+2);
    trace("R4 dip in hold", POR+6, 0, 0, 4, 4+SENS-1, NONE, POR+3, NONE);

    // R8: qualification on the completion edge wins
    trace("R5 drop to wait b", SENS+6, 1, NONE, 0, NONE, SENS+2, NONE, SENS+2);
    trace("R8 collision", 2*POR+10, 0, 0, POR-SENS+1, POR+3, NONE,
          2*POR+6, POR+3);

    // R8/R7: qualification one edge after completion: release then drop
    trace("R5 drop to wait c", SENS+6, 1, NONE, 0, NONE, SENS+2, NONE, SENS+2);
    trace("R8 late dip", POR+6, 0, 0, POR-SENS+2, POR+4, POR+4, POR+3, POR+4);
    trace("R6 late recover", POR+4, 0, NONE, NONE, NONE, NONE, POR+1, NONE);

    // R10: asynchronous reset while released, then fresh sequence
    #2 rst_n = 1'b0;
    #1;
    chk("R10 async rst_no", rst_o, 0);
    chk("R10 async seq_done_o", done_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    trace("R10 R3 restart", POR+6, 0, NONE, NONE, NONE, NONE, POR+3, NONE);

    summary();
    $finish;
  end

endmodule